// File: doc/BRIEF.md
# RFID AFI Lock Command Handler

This block sits behind the demodulator of a 13.56 MHz vicinity tag. It takes a frame that arrives one byte per strobe, framed by start and end events. It recognises the command that freezes the Application Family Identifier, which may be addressed to one tag by its 64-bit UID. It verifies the frame CRC, and when the frame is good it runs a timed non-volatile write that sets a one-time lock bit. When the write is done it emits a short response frame. In this block the non-volatile cell is modelled by a register that only reset clears.

An active-low busy pin has two timing modes, chosen by a configuration input. In whole-transaction mode the pin covers the time from the request start to the end of the response. In write mode it covers only the internal write. Time is counted in clock cycles: one parameter gives the nominal turnaround delay, and another gives the cycles per 302 µs slot. The write lasts that turnaround plus 18 slots.

Top module: `afi_lock_handler`

## Requirements
- R1: A frame is accepted when its second byte is 0x28, its length is exactly flags + command (+ UID) + two CRC bytes, and its last two bytes (low byte first) equal the complement of the CRC over all earlier bytes. The CRC is reflected polynomial 0x8408 with preset 0xFFFF, taking data LSB first.
- R2: When bit 5 of the flags byte is set, eight UID bytes follow the command byte, least significant byte first, and all of them must equal `uid_i`. A mismatch makes the frame ignored.
- R3: A frame with a bad CRC, a wrong length, a wrong command or a wrong UID produces no response and leaves the lock bit unchanged. In whole-transaction mode the busy pin returns high in the cycle after `rx_eof_i`.
- R4: An accepted frame with the lock clear starts a write of T1_CYC + 18·SLOT_CYC cycles. The lock bit reads 1 from the first cycle after the write.
- R5: The response is a `tx_sof_o` pulse, then one `tx_vld_o` byte per cycle, then a `tx_eof_o` pulse, all in consecutive cycles. A success carries flags 0x00 followed by the CRC low byte and the CRC high byte.
- R6: An accepted frame while already locked performs no write. After T1_CYC cycles it answers with flags 0x01, error code 0x12 and the CRC.
- R7: Once set, the lock bit stays set until reset, whatever frames arrive.
- R8: With `busy_mode_i`=0 the busy pin is low from the cycle after `rx_sof_i` until the `tx_eof_o` cycle, inclusive.
- R9: With `busy_mode_i`=1 the busy pin is low exactly during the write cycles and high at all other times.
- R10: When bit 6 of the request flags is set, the response starts in the cycle after the first `rx_eof_i` that arrives once the write (or error delay) has ended.
- R11: After reset the busy pin is high, no transmit strobe is active and the lock bit is 0.
- R12: Start, byte and end strobes that arrive during a write, a delay or a response are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_mode_i | input | 1 | 0: whole-transaction busy, 1: write-only busy |
| uid_i | input | 64 | This tag's UID |
| rx_sof_i | input | 1 | Request start-of-frame strobe |
| rx_vld_i | input | 1 | Request byte strobe |
| rx_byte_i | input | 8 | Request byte |
| rx_eof_i | input | 1 | Request end-of-frame strobe, also the option-mode trigger |
| tx_sof_o | output | 1 | Response start-of-frame pulse |
| tx_vld_o | output | 1 | Response byte valid |
| tx_byte_o | output | 8 | Response byte (0 when not valid) |
| tx_eof_o | output | 1 | Response end-of-frame pulse |
| busy_n_o | output | 1 | Active-low busy / write-in-progress |
| afi_locked_o | output | 1 | Lock bit state |

## Verification
The hardest cases to reach are the option-flag wait and the already-locked error path. Reaching the option wait needs a request that is both valid and timed-out, followed by a late trigger. Reaching the error path needs a first complete lock cycle before it. The stimulus locks the tag with an addressed request in write-only mode and, while that write runs, sends a second request that must be ignored. It then repeats the lock in whole-transaction mode to draw the error response. After a reset, option-flag requests are held in the wait state for many idle cycles before the trigger, once on the success path and once on the error path.

// File: rtl/afi_lock_pkg.sv
package afi_lock_pkg;

    localparam logic [7:0]  CMD_LOCK_AFI      = 8'h28;
    localparam int          FLAG_ADDR_BIT     = 5;
    localparam int          FLAG_OPT_BIT      = 6;
    localparam int          UID_BYTES         = 8;
    localparam logic [15:0] CRC_PRESET        = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL     = 16'h8408;
    localparam logic [15:0] CRC_GOOD_RESIDUE  = 16'hF0B8;
    localparam logic [7:0]  RSP_FLAGS_OK      = 8'h00;
    localparam logic [7:0]  RSP_FLAGS_ERR     = 8'h01;
    localparam logic [7:0]  ERR_ALREADY_LOCKED = 8'h12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_WRITE,
        ST_DELAY,
        ST_WAIT,
        ST_RESP
    } hdl_state_e;

    // One byte through the reflected CRC register, LSB first.
    function automatic logic [15:0] crc16_byte(logic [15:0] crc, logic [7:0] data);
        logic [15:0] c;
        c = crc ^ {8'h00, data};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/afi_cycle_timer.sv
module afi_cycle_timer #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/afi_req_parser.sv
module afi_req_parser
    import afi_lock_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        clr_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    input  logic [63:0] uid_i,
    output logic        frame_ok_o,
    output logic        opt_o
);

    localparam logic [3:0] LEN_PLAIN = 4'd4;
    localparam logic [3:0] LEN_ADDR  = 4'(4 + UID_BYTES);
    localparam logic [3:0] UID_FIRST = 4'd2;
    localparam logic [3:0] UID_LAST  = 4'(1 + UID_BYTES);

    typedef struct packed {
        logic [3:0]  cnt;
        logic        addr;
        logic        opt;
        logic [7:0]  cmd;
        logic        uid_ok;
        logic [15:0] crc;
    } prs_t;

    prs_t prs_d, prs_q;
    logic [2:0] uid_sel;

    assign uid_sel = prs_q.cnt[2:0] - 3'd2;

    always_comb begin
        prs_d = prs_q;
        if (clr_i) begin
            prs_d.cnt    = '0;
            prs_d.addr   = 1'b0;
            prs_d.opt    = 1'b0;
            prs_d.cmd    = '0;
            prs_d.uid_ok = 1'b1;
            prs_d.crc    = CRC_PRESET;
        end else if (byte_vld_i) begin
            prs_d.crc = crc16_byte(prs_q.crc, byte_i);
            if (prs_q.cnt != 4'hF) prs_d.cnt = prs_q.cnt + 4'd1;
            if (prs_q.cnt == 4'd0) begin
                prs_d.addr = byte_i[FLAG_ADDR_BIT];
                prs_d.opt  = byte_i[FLAG_OPT_BIT];
            end
            if (prs_q.cnt == 4'd1) prs_d.cmd = byte_i;
            if (prs_q.addr && prs_q.cnt >= UID_FIRST && prs_q.cnt <= UID_LAST) begin
                if (byte_i != uid_i[{uid_sel, 3'b000} +: 8]) prs_d.uid_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prs_q <= '0;
        else         prs_q <= prs_d;
    end

    assign frame_ok_o = (prs_q.cmd == CMD_LOCK_AFI)
                     && (prs_q.cnt == (prs_q.addr ? LEN_ADDR : LEN_PLAIN))
                     && prs_q.uid_ok
                     && (prs_q.crc == CRC_GOOD_RESIDUE);
    assign opt_o = prs_q.opt;

endmodule

// File: rtl/afi_lock_handler.sv
module afi_lock_handler
    import afi_lock_pkg::*;
#(
    parameter int T1_CYC   = 4,
    parameter int SLOT_CYC = 2,
    parameter int WR_SLOTS = 18
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        busy_mode_i,
    input  logic [63:0] uid_i,
    input  logic        rx_sof_i,
    input  logic        rx_vld_i,
    input  logic [7:0]  rx_byte_i,
    input  logic        rx_eof_i,
    output logic        tx_sof_o,
    output logic        tx_vld_o,
    output logic [7:0]  tx_byte_o,
    output logic        tx_eof_o,
    output logic        busy_n_o,
    output logic        afi_locked_o
);

    localparam int          WR_CYC  = T1_CYC + WR_SLOTS * SLOT_CYC;
    localparam int          TMR_W   = $clog2(WR_CYC + 1);
    localparam logic [15:0] CRC_OK  = ~crc16_byte(CRC_PRESET, RSP_FLAGS_OK);
    localparam logic [15:0] CRC_ERR = ~crc16_byte(crc16_byte(CRC_PRESET, RSP_FLAGS_ERR),
                                                  ERR_ALREADY_LOCKED);

    typedef struct packed {
        hdl_state_e st;
        logic [2:0] idx;
        logic       opt;
        logic       err;
        logic       locked;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             prs_clr, prs_byte, frame_ok, frame_opt;
    logic             tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    logic [2:0]       last_idx;

    assign prs_byte = (ctl_q.st == ST_RX) && rx_vld_i && !rx_sof_i && !rx_eof_i;
    assign last_idx = ctl_q.err ? 3'd5 : 3'd4;

    afi_req_parser u_parser (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (prs_clr),
        .byte_vld_i (prs_byte),
        .byte_i     (rx_byte_i),
        .uid_i      (uid_i),
        .frame_ok_o (frame_ok),
        .opt_o      (frame_opt)
    );

    afi_cycle_timer #(.W(TMR_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    always_comb begin
        ctl_d    = ctl_q;
        prs_clr  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (rx_sof_i) begin
                    ctl_d.st = ST_RX;
                    prs_clr  = 1'b1;
                end
            end
            ST_RX: begin
                if (rx_sof_i) begin
                    prs_clr = 1'b1;
                end else if (rx_eof_i) begin
                    if (!frame_ok) begin
                        ctl_d.st = ST_IDLE;
                    end else begin
                        ctl_d.opt = frame_opt;
                        ctl_d.err = ctl_q.locked;
                        tmr_load  = 1'b1;
                        if (ctl_q.locked) begin
                            ctl_d.st = ST_DELAY;
                            tmr_val  = TMR_W'(T1_CYC - 1);
                        end else begin
                            ctl_d.st = ST_WRITE;
                            tmr_val  = TMR_W'(WR_CYC - 1);
                        end
                    end
                end
            end
            ST_WRITE, ST_DELAY: begin
                if (tmr_done) begin
                    if (ctl_q.st == ST_WRITE) ctl_d.locked = 1'b1;
                    ctl_d.st  = ctl_q.opt ? ST_WAIT : ST_RESP;
                    ctl_d.idx = '0;
                end
            end
            ST_WAIT: begin
                if (rx_eof_i) begin
                    ctl_d.st  = ST_RESP;
                    ctl_d.idx = '0;
                end
            end
            ST_RESP: begin
                if (ctl_q.idx == last_idx) ctl_d.st = ST_IDLE;
                else                       ctl_d.idx = ctl_q.idx + 3'd1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '{st: ST_IDLE, idx: 3'd0, opt: 1'b0, err: 1'b0, locked: 1'b0};
        else         ctl_q <= ctl_d;
    end

    always_comb begin
        tx_byte_o = 8'h00;
        if (tx_vld_o) begin
            unique case (ctl_q.idx)
                3'd1:    tx_byte_o = ctl_q.err ? RSP_FLAGS_ERR      : RSP_FLAGS_OK;
                3'd2:    tx_byte_o = ctl_q.err ? ERR_ALREADY_LOCKED : CRC_OK[7:0];
                3'd3:    tx_byte_o = ctl_q.err ? CRC_ERR[7:0]       : CRC_OK[15:8];
                3'd4:    tx_byte_o = CRC_ERR[15:8];
                default: tx_byte_o = 8'h00;
            endcase
        end
    end

    assign tx_sof_o     = (ctl_q.st == ST_RESP) && (ctl_q.idx == 3'd0);
    assign tx_eof_o     = (ctl_q.st == ST_RESP) && (ctl_q.idx == last_idx);
    assign tx_vld_o     = (ctl_q.st == ST_RESP) && (ctl_q.idx != 3'd0) && (ctl_q.idx != last_idx);
    assign busy_n_o     = busy_mode_i ? (ctl_q.st != ST_WRITE) : (ctl_q.st == ST_IDLE);
    assign afi_locked_o = ctl_q.locked;

endmodule

// File: rtl/afi_lock_handler_chk.sv
module afi_lock_handler_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic busy_mode_i,
    input logic tx_sof_o,
    input logic tx_vld_o,
    input logic tx_eof_o,
    input logic busy_n_o,
    input logic afi_locked_o
);

    AST_TX_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({tx_sof_o, tx_vld_o, tx_eof_o})); // R5

    AST_TX_EOF_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_eof_o |=> !tx_vld_o && !tx_eof_o); // R5

    AST_LOCK_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(afi_locked_o) |-> !$past(busy_n_o)); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        afi_locked_o |=> afi_locked_o); // R7

    AST_TXN_BUSY_COVERS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_mode_i && (tx_sof_o || tx_vld_o || tx_eof_o)) |-> !busy_n_o); // R8

    AST_WIP_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_mode_i && !busy_n_o) |-> !(tx_sof_o || tx_vld_o || tx_eof_o)); // R9

endmodule

bind afi_lock_handler afi_lock_handler_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_mode_i  (busy_mode_i),
    .tx_sof_o     (tx_sof_o),
    .tx_vld_o     (tx_vld_o),
    .tx_eof_o     (tx_eof_o),
    .busy_n_o     (busy_n_o),
    .afi_locked_o (afi_locked_o)
);

// File: tb/afi_lock_handler_tb_top.sv
module afi_lock_handler_tb_top;

    localparam int T1   = 4;
    localparam int SLOT = 2;
    localparam int WRC  = T1 + 18 * SLOT;
    localparam logic [63:0] MY_UID = 64'hE007_A1B2_C3D4_E5F6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_mode = 1'b0;
    logic       rx_sof = 1'b0, rx_vld = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_sof, tx_vld, tx_eof, busy_n, locked;
    logic [7:0] tx_byte;

    always #4 clk = ~clk;

    afi_lock_handler #(.T1_CYC(T1), .SLOT_CYC(SLOT), .WR_SLOTS(18)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .busy_mode_i(busy_mode), .uid_i(MY_UID),
        .rx_sof_i(rx_sof), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte), .rx_eof_i(rx_eof),
        .tx_sof_o(tx_sof), .tx_vld_o(tx_vld), .tx_byte_o(tx_byte), .tx_eof_o(tx_eof),
        .busy_n_o(busy_n), .afi_locked_o(locked)
    );

    typedef struct packed {
        logic       busy_n;
        logic       sof;
        logic       vld;
        logic [7:0] data;
        logic       eof;
        logic       lk;
    } obs_t;

    obs_t       plan[$];
    obs_t       pend;
    logic [7:0] rxq[$];
    logic [7:0] frm[$];
    int  checks = 0, errors = 0, cur_req = 11;
    bit  in_frame, waiting, m_locked, resp_err, mode_sel, finished;

    function automatic logic [15:0] crc_over(input logic [7:0] d[$], input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ d[i][k];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    function automatic obs_t mk(logic b, logic s, logic v, logic [7:0] d, logic e, logic l);
        return {b, s, v, d, e, l};
    endfunction

    function automatic bit frame_ok();
        int n = rxq.size();
        logic [15:0] c;
        if (n < 1) return 0;
        if (n != (rxq[0][5] ? 12 : 4)) return 0;
        if (rxq[1] != 8'h28) return 0;
        if (rxq[0][5]) begin
            for (int i = 0; i < 8; i++) if (rxq[2+i] != MY_UID[8*i +: 8]) return 0;
        end
        c = ~crc_over(rxq, n - 2);
        return (rxq[n-2] == c[7:0]) && (rxq[n-1] == c[15:8]);
    endfunction

    task automatic push_resp();
        logic [7:0] r[$];
        logic [15:0] c;
        if (resp_err) begin r.push_back(8'h01); r.push_back(8'h12); end
        else          r.push_back(8'h00);
        c = ~crc_over(r, r.size());
        r.push_back(c[7:0]); r.push_back(c[15:8]);
        plan.push_back(mk(busy_mode, 1, 0, 8'h00, 0, 1));
        foreach (r[i]) plan.push_back(mk(busy_mode, 0, 1, r[i], 0, 1));
        plan.push_back(mk(busy_mode, 0, 0, 8'h00, 1, 1));
    endtask

    // Reference model: the outputs expected after the coming edge for these inputs.
    task automatic predict(input bit s, input bit v, input logic [7:0] b, input bit e, output obs_t r);
        if (plan.size() > 0) begin r = plan.pop_front(); return; end
        if (waiting) begin
            if (e) begin waiting = 0; push_resp(); r = plan.pop_front(); end
            else r = mk(busy_mode, 0, 0, 8'h00, 0, m_locked);
            return;
        end
        if (!in_frame && !s) begin r = mk(1, 0, 0, 8'h00, 0, m_locked); return; end
        if (s) begin
            in_frame = 1; rxq.delete();
            r = mk(busy_mode, 0, 0, 8'h00, 0, m_locked);
            return;
        end
        if (e) begin
            in_frame = 0;
            if (!frame_ok()) begin r = mk(1, 0, 0, 8'h00, 0, m_locked); return; end
            if (m_locked) begin
                resp_err = 1;
                for (int i = 0; i < T1; i++) plan.push_back(mk(busy_mode, 0, 0, 8'h00, 0, 1));
            end else begin
                resp_err = 0;
                for (int i = 0; i < WRC; i++) plan.push_back(mk(0, 0, 0, 8'h00, 0, 0));
                m_locked = 1;
            end
            if (rxq[0][6]) begin
                plan.push_back(mk(busy_mode, 0, 0, 8'h00, 0, 1));
                waiting = 1;
            end else begin
                push_resp();
            end
            r = plan.pop_front();
            return;
        end
        if (v) rxq.push_back(b);
        r = mk(busy_mode, 0, 0, 8'h00, 0, m_locked);
    endtask

    task automatic compare();
        obs_t act;
        act = {busy_n, tx_sof, tx_vld, tx_byte, tx_eof, locked};
        checks++;
        if (act !== pend) begin
            errors++;
            $display("FAIL R%0d t=%0t actual %b expected %b (busy_n,sof,vld,byte,eof,lock)",
                     cur_req, $time, act, pend);
        end
    endtask

    task automatic cyc(input bit s, input bit v, input logic [7:0] b, input bit e);
        obs_t nx;
        @(negedge clk);
        compare();
        busy_mode = mode_sel;
        rx_sof = s; rx_vld = v; rx_byte = b; rx_eof = e;
        predict(s, v, b, e, nx);
        pend = nx;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; busy_mode = mode_sel;
        rx_sof = 0; rx_vld = 0; rx_eof = 0; rx_byte = 8'h00;
        plan.delete(); rxq.delete();
        waiting = 0; in_frame = 0; m_locked = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pend = mk(1, 0, 0, 8'h00, 0, 0);
    endtask

    task automatic build(input logic [7:0] flags, input logic [7:0] cmd,
                         input bit bad_crc, input bit extra, input bit bad_uid);
        logic [15:0] c;
        frm.delete();
        frm.push_back(flags); frm.push_back(cmd);
        if (flags[5]) begin
            for (int i = 0; i < 8; i++)
                frm.push_back(MY_UID[8*i +: 8] ^ ((bad_uid && i == 3) ? 8'h01 : 8'h00));
        end
        c = ~crc_over(frm, frm.size());
        if (bad_crc) c = c ^ 16'h0100;
        frm.push_back(c[7:0]); frm.push_back(c[15:8]);
        if (extra) frm.push_back(8'h55);
    endtask

    task automatic send();
        cyc(1, 0, 8'h00, 0);
        foreach (frm[i]) cyc(0, 1, frm[i], 0);
        cyc(0, 0, 8'h00, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mode_sel = 0;
        do_reset();
        cur_req = 11; idle(3);                       // R11 reset state
        cur_req = 3;                                 // R3 ignored frames
        build(8'h02, 8'h28, 1, 0, 0); send(); idle(4);
        build(8'h02, 8'h27, 0, 0, 0); send(); idle(4);
        build(8'h02, 8'h28, 0, 1, 0); send(); idle(4);
        cur_req = 2;                                 // R2 UID mismatch
        build(8'h22, 8'h28, 0, 0, 1); send(); idle(4);
        cur_req = 9; mode_sel = 1; idle(2);          // R9 write-only busy, R2 addressed lock
        build(8'h22, 8'h28, 0, 0, 0); send();
        cur_req = 12;                                // R12 frame during the write is ignored
        build(8'h02, 8'h28, 0, 0, 0); send();
        cur_req = 4; idle(WRC + 10);                 // R4 R5 timing and response bytes
        cur_req = 6; mode_sel = 0; idle(2);          // R6 R7 R8 relock gives error, lock stays
        build(8'h02, 8'h28, 0, 0, 0); send(); idle(T1 + 10);
        cur_req = 10; do_reset(); idle(2);           // R10 option wait, success path
        build(8'h42, 8'h28, 0, 0, 0); send(); idle(WRC + 12);
        cyc(0, 0, 8'h00, 1); idle(8);
        mode_sel = 1; idle(2);                       // R10 option wait, error path
        build(8'h42, 8'h28, 0, 0, 0); send(); idle(T1 + 9);
        cyc(0, 0, 8'h00, 1); idle(8);
        cur_req = 1; mode_sel = 0; do_reset(); idle(2); // R1 plain unaddressed lock
        build(8'h02, 8'h28, 0, 0, 0); send(); idle(WRC + 10);
        cur_req = 8; idle(2);                        // R8 idle after response
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule